// File: doc/BRIEF.md
# Sub-Vector Horizontal Fold Unit

This unit walks a vector of elements, each made of one to four lanes (x, y, z, w), and emits one result per element or per lane. A run begins with a one-cycle `start` pulse that latches the vector length, the sub-vector length, the mode bit, the record-condition flag, the operator code and the destination base slot. The unit then takes one lane per cycle from a valid/ready stream, always in lane order x, y, z, w.

In horizontal mode, which applies when the mode bit is set and the sub-vector length exceeds one, each element is folded into a single scalar. The accumulator is loaded with lane x as it arrives, and every later lane is combined into it with the selected operator. The reduced value goes to destination slot base+i for element i. With the mode bit clear, each lane leaves unchanged as its own result and is tagged with its lane index. When the record flag is set, each result carries a 4-bit condition field. Only final results carry one; partial folds never do.

Top module: `subvec_fold_unit`

## Requirements
- R1: After reset `out_valid`, `out_cr_valid`, `done`, `busy` and `in_ready` are all low.
- R2: In horizontal mode (mode bit set, `cfg_svl` not 0) an element's result equals lane x combined with y, then z, then w, in that order, up to `cfg_svl`+1 lanes (`cfg_svl` encodes lanes minus one). Lane x is not combined with itself. There is one result per element, and `out_lane` is 0.
- R3: Operator codes, each applied as op(accumulator, lane): 0 add modulo 2^64, 1 AND, 2 OR, 3 XOR, 4 signed minimum, 5 signed maximum, 6 unsigned minimum, 7 unsigned maximum.
- R4: `out_valid` is high for exactly one cycle: the cycle after the clock edge that accepts the last lane of a result. No result appears for intermediate lanes of a folded element.
- R5: `out_slot` equals `cfg_base` plus the element index, modulo 2^SLOTW, and results leave in element order.
- R6: With the record flag set, `out_cr_valid` accompanies each result and `out_cr` is {lt, gt, eq, so}: bit 3 is set for result < 0, bit 2 for result > 0 and bit 1 for result == 0 (signed), with bit 0 held at 0. With the flag clear, `out_cr_valid` and `out_cr` are 0.
- R7: With the mode bit clear and `cfg_svl` not 0, each lane is output unchanged as its own result, with `out_lane` set to its lane index (0 to 3) and `out_slot` set to base plus the element index.
- R8: With `cfg_svl` = 0 (one lane), each element is output unchanged whatever the mode bit is.
- R9: `done` is a one-cycle pulse in the same cycle as the run's final result. In the following cycle `busy` and `in_ready` are low.
- R10: A start with `cfg_vl` = 0 produces no result. `done` pulses in the cycle after the start, and `busy` stays low.
- R11: A `start` pulse while `busy` is high is ignored. The run in progress keeps its settings and does not restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run and latch the cfg_* inputs (only while idle) |
| cfg_vl | input | VLW | Number of elements |
| cfg_svl | input | 2 | Lanes per element minus one |
| cfg_horiz | input | 1 | Horizontal fold mode bit |
| cfg_rec | input | 1 | Produce a condition field per result |
| cfg_op | input | 3 | Operator code |
| cfg_base | input | SLOTW | Destination slot of element 0 |
| in_valid | input | 1 | Lane data valid |
| in_data | input | DW | Lane value |
| in_ready | output | 1 | Unit accepts a lane this cycle |
| out_valid | output | 1 | Result valid |
| out_data | output | DW | Result value |
| out_slot | output | SLOTW | Destination slot of the result |
| out_lane | output | 2 | Lane index in independent mode, else 0 |
| out_cr | output | 4 | Condition field {lt, gt, eq, so} |
| out_cr_valid | output | 1 | Condition field valid |
| done | output | 1 | Run complete pulse |
| busy | output | 1 | Run in progress |

## Verification
The final result of a run and the `done` pulse fall in the same cycle. Both are launched by the edge that accepts the last lane of the last element. Every run is driven through to its last lane, in folded, independent and single-lane configurations. On each result cycle the monitor requires `done` to be high exactly when its expected-result queue has just emptied, and low otherwise. A `done` without a result is accepted only for a zero-length run.

// File: rtl/subvec_fold_unit.sv
module subvec_fold_unit #(
  parameter int DW    = 64,
  parameter int VLW   = 7,
  parameter int SLOTW = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VLW-1:0]   cfg_vl,
  input  logic [1:0]       cfg_svl,
  input  logic             cfg_horiz,
  input  logic             cfg_rec,
  input  logic [2:0]       cfg_op,
  input  logic [SLOTW-1:0] cfg_base,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic [SLOTW-1:0] out_slot,
  output logic [1:0]       out_lane,
  output logic [3:0]       out_cr,
  output logic             out_cr_valid,
  output logic             done,
  output logic             busy
);

  logic [VLW-1:0]   vl_q, elem_q;
  logic [1:0]       svl_q, lane_q;
  logic             horiz_q, rec_q;
  logic [2:0]       op_q;
  logic [SLOTW-1:0] base_q;
  logic [DW-1:0]    acc_q;

  function automatic logic [DW-1:0] apply_op(input logic [2:0] op,
                                             input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    case (op)
      3'd0: apply_op = a + b;
      3'd1: apply_op = a & b;
      3'd2: apply_op = a | b;
      3'd3: apply_op = a ^ b;
      3'd4: apply_op = ($signed(a) < $signed(b)) ? a : b;
      3'd5: apply_op = ($signed(a) > $signed(b)) ? a : b;
      3'd6: apply_op = (a < b) ? a : b;
      default: apply_op = (a > b) ? a : b;
    endcase
  endfunction

  wire             fold_mode = horiz_q && (svl_q != 2'd0);
  wire             take      = in_valid && in_ready;
  wire             last_lane = (lane_q == svl_q);
  wire             last_elem = (elem_q == vl_q - VLW'(1));
  wire             emit      = fold_mode ? last_lane : 1'b1;
  wire [DW-1:0]    folded    = (fold_mode && lane_q != 2'd0) ? apply_op(op_q, acc_q, in_data) : in_data;
  wire             neg       = folded[DW-1];
  wire             zero      = (folded == '0);

  assign in_ready = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      done         <= 1'b0;
      out_valid    <= 1'b0;
      out_cr_valid <= 1'b0;
      out_data     <= '0;
      out_slot     <= '0;
      out_lane     <= '0;
      out_cr       <= '0;
      vl_q         <= '0;
      elem_q       <= '0;
      svl_q        <= '0;
      lane_q       <= '0;
      horiz_q      <= 1'b0;
      rec_q        <= 1'b0;
      op_q         <= '0;
      base_q       <= '0;
      acc_q        <= '0;
    end else begin
      done         <= 1'b0;
      out_valid    <= 1'b0;
      out_cr_valid <= 1'b0;
      if (!busy && start) begin
        vl_q    <= cfg_vl;
        svl_q   <= cfg_svl;
        horiz_q <= cfg_horiz;
        rec_q   <= cfg_rec;
        op_q    <= cfg_op;
        base_q  <= cfg_base;
        elem_q  <= '0;
        lane_q  <= '0;
        if (cfg_vl == '0) done <= 1'b1;
        else              busy <= 1'b1;
      end
      if (take) begin
        acc_q <= folded;
        if (emit) begin
          out_valid    <= 1'b1;
          out_data     <= folded;
          out_slot     <= base_q + SLOTW'(elem_q);
          out_lane     <= fold_mode ? 2'd0 : lane_q;
          out_cr_valid <= rec_q;
          out_cr       <= rec_q ? {neg, !neg && !zero, zero, 1'b0} : 4'b0;
        end
        if (last_lane) begin
          lane_q <= '0;
          elem_q <= elem_q + VLW'(1);
          if (last_elem) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          lane_q <= lane_q + 2'd1;
        end
      end
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !out_valid && !done);

  p_result_after_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready));

  p_cr_one_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_cr_valid |-> out_valid && ($countones(out_cr[3:1]) == 1) && !out_cr[0]);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  p_empty_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cfg_vl == '0) |=> done && !busy && !out_valid);

  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(vl_q) && $stable(op_q) && $stable(base_q));

endmodule

// File: tb/subvec_fold_unit_bench.sv
module subvec_fold_unit_bench;
  localparam int DW = 64, VLW = 7, SLOTW = 7;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic             start = 0, cfg_horiz = 0, cfg_rec = 0, in_valid = 0;
  logic [VLW-1:0]   cfg_vl = '0;
  logic [1:0]       cfg_svl = '0;
  logic [2:0]       cfg_op = '0;
  logic [SLOTW-1:0] cfg_base = '0;
  logic [DW-1:0]    in_data = '0;
  logic             in_ready, out_valid, out_cr_valid, done, busy;
  logic [DW-1:0]    out_data;
  logic [SLOTW-1:0] out_slot;
  logic [1:0]       out_lane;
  logic [3:0]       out_cr;

  subvec_fold_unit #(.DW(DW), .VLW(VLW), .SLOTW(SLOTW)) u_subvec_fold_unit (
    .clk, .rst_n, .start, .cfg_vl, .cfg_svl, .cfg_horiz, .cfg_rec, .cfg_op, .cfg_base,
    .in_valid, .in_data, .in_ready, .out_valid, .out_data, .out_slot, .out_lane,
    .out_cr, .out_cr_valid, .done, .busy);

  typedef struct packed {
    logic [DW-1:0]    data;
    logic [SLOTW-1:0] slot;
    logic [1:0]       lane;
    logic [3:0]       cr;
    logic             crv;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0;
  bit zero_run = 0;
  string cur_req = "R2";

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_op(input logic [2:0] op, input logic [DW-1:0] a,
                                           input logic [DW-1:0] b);
    logic signed [DW-1:0] sa, sb;
    sa = a; sb = b;
    case (op)
      0: return a + b;
      1: return a & b;
      2: return a | b;
      3: return a ^ b;
      4: return (sa <= sb) ? a : b;
      5: return (sa >= sb) ? a : b;
      6: return (a <= b) ? a : b;
      default: return (a >= b) ? a : b;
    endcase
  endfunction

  function automatic logic [3:0] ref_cr(input logic [DW-1:0] v);
    logic signed [DW-1:0] s;
    s = v;
    return {s < 0, s > 0, s == 0, 1'b0};
  endfunction

  function automatic logic [DW-1:0] gen(input int seed, input int k);
    logic [DW-1:0] m;
    m = 64'h9E37_79B9_7F4A_7C15 * DW'(k + 1);
    return m ^ DW'(seed) ^ (DW'(seed) << 40);
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(0, cur_req, "unexpected result", out_data, '0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(out_data == e.data, cur_req, "data", out_data, e.data);
          check(out_slot == e.slot, "R5", "slot", DW'(out_slot), DW'(e.slot));
          check(out_lane == e.lane, cur_req, "lane", DW'(out_lane), DW'(e.lane));
          check(out_cr_valid == e.crv && out_cr == e.cr, "R6", "cr", DW'({out_cr_valid, out_cr}),
                DW'({e.crv, e.cr}));
        end
        check(done == (exp_q.size() == 0), "R9", "done with final result", DW'(done),
              DW'(exp_q.size() == 0));
      end else if (done) begin
        check(zero_run, "R10", "done without result", DW'(done), DW'(zero_run));
      end
    end
  end

  task automatic run(input string req, input logic [2:0] op, input logic [1:0] svl,
                     input bit horiz, input bit rec, input int vl, input int base,
                     input int seed, input bit bubbles, input bit poke_start);
    bit fold;
    int k;
    fold = horiz && svl != 0;
    cur_req = req;
    k = 0;
    for (int e = 0; e < vl; e++) begin
      logic [DW-1:0] acc;
      for (int l = 0; l <= int'(svl); l++) begin
        logic [DW-1:0] v;
        exp_t x;
        v = gen(seed, e * 4 + l);
        acc = (fold && l != 0) ? ref_op(op, acc, v) : v;
        if (!fold || l == int'(svl)) begin
          x.data = acc; x.slot = SLOTW'(base + e); x.lane = fold ? 2'd0 : 2'(l);
          x.crv = rec; x.cr = rec ? ref_cr(acc) : 4'b0;
          exp_q.push_back(x);
        end
      end
    end
    @(negedge clk);
    start = 1; cfg_op = op; cfg_svl = svl; cfg_horiz = horiz; cfg_rec = rec;
    cfg_vl = VLW'(vl); cfg_base = SLOTW'(base);
    @(negedge clk);
    start = 0; cfg_vl = VLW'(9); cfg_op = 3'd7; cfg_base = '0;
    for (int e = 0; e < vl; e++) begin
      for (int l = 0; l <= int'(svl); l++) begin
        if (bubbles && ((k % 3) == 1)) begin
          in_valid = 0;
          @(negedge clk);
          check(out_valid == 0 || !fold || l == 0, "R4", "no result on bubble", DW'(out_valid), 0);
        end
        in_valid = 1; in_data = gen(seed, e * 4 + l);
        start = poke_start && k == 1;
        k++;
        @(negedge clk);
        start = 0;
        if (fold && l != int'(svl))
          check(!out_valid, "R4", "no partial result", DW'(out_valid), 0);
      end
    end
    in_valid = 0;
    @(negedge clk);
    check(!busy && !in_ready, "R9", "idle after done", DW'({busy, in_ready}), 0);
    check(exp_q.size() == 0, req, "results outstanding", DW'(exp_q.size()), 0);
    if (poke_start)
      check(!busy && !out_valid, "R11", "start while busy ignored", DW'({busy, out_valid}), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(0, "WD", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !out_cr_valid && !done && !busy && !in_ready, "R1", "reset state",
          DW'({out_valid, out_cr_valid, done, busy, in_ready}), 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done, "R1", "idle after reset", DW'({busy, done}), 0);

    run("R2", 3'd0, 2'd3, 1, 1, 3, 5, 11, 0, 0);   // add, wraps
    run("R3", 3'd4, 2'd2, 1, 1, 3, 20, 37, 1, 0);  // signed min
    run("R3", 3'd3, 2'd1, 1, 0, 2, 40, 99, 0, 0);  // xor, no cr
    run("R3", 3'd1, 2'd3, 1, 1, 2, 0, 5, 0, 0);
    run("R3", 3'd2, 2'd3, 1, 1, 2, 0, 6, 1, 0);
    run("R3", 3'd5, 2'd3, 1, 1, 2, 0, 7, 0, 0);
    run("R3", 3'd6, 2'd2, 1, 1, 2, 0, 8, 0, 0);
    run("R3", 3'd7, 2'd2, 1, 0, 2, 0, 9, 1, 0);
    run("R7", 3'd0, 2'd2, 0, 1, 2, 60, 13, 1, 0);
    run("R8", 3'd0, 2'd0, 1, 1, 4, 70, 17, 0, 0);
    run("R5", 3'd0, 2'd1, 1, 1, 4, 126, 19, 0, 0); // slot wraps
    run("R11", 3'd0, 2'd3, 1, 1, 2, 3, 23, 0, 1);

    // R10: zero-length run
    zero_run = 1;
    @(negedge clk);
    start = 1; cfg_vl = '0;
    @(negedge clk);
    start = 0;
    check(done && !out_valid && !busy, "R10", "empty run", DW'({done, out_valid, busy}), 3'b100);
    @(negedge clk);
    check(!done, "R10", "done single pulse", DW'(done), 0);
    zero_run = 0;

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule